// File: doc/BRIEF.md
# Regulator Fault Protection Supervisor

This block turns five already-synchronized comparator flags from a multiphase voltage regulator into the protective response of the power stage. A microsecond tick paces two persistence timers. An overcurrent flag must stay high for a set number of ticks before it counts as a fault. An imbalance flag, which means more than 9 mV of spread between the phase current-sense pins, needs a longer hold. The block drives power-good, the PWM enable and a command that forces the low-side switches on. It also keeps a code for the first fault seen.

Faults of the latch-off kind are plain overcurrent, way-overcurrent (above 1.5 times the limit, acting at once) and imbalance. Each stops all switching and drops power-good, and they stay that way until reset or a re-arm pulse. Overvoltage, meaning the output is more than 200 mV above target, works differently. Power-good drops and the low-side switches are forced on to pull the output down. When the output is reported below target, every switch is released. If overvoltage comes back, the pull-down starts again.

Top module: `reg_fault_supervisor`

## Requirements
- R1: After reset, `pgood` and `pwm_en` are 1, `lowside_on` is 0 and `fault_code` is 0 (no fault).
- R2: With `oc_flag` held high, no fault exists after OC_US-1 ticks. The overcurrent fault (code 2) is in force one clock after the clock that registers tick number OC_US (default 120).
- R3: If `oc_flag` or `imb_flag` drops for even one clock, its tick count restarts from zero. Two runs of 100 ticks separated by a one-clock gap cause no fault.
- R4: A `woc_flag` sampled high at a clock edge drives `pgood` and `pwm_en` low from that edge on, with code 1.
- R5: With `imb_flag` held high, the imbalance fault (code 3) is in force one clock after tick number IMB_US (default 1000), and not before.
- R6: After a latch-off fault (code 1, 2 or 3) and with no overvoltage, `pgood` and `pwm_en` stay 0 and `lowside_on` stays 0, even after the flag is removed, until `rearm` or reset.
- R7: An `ov_flag` sampled high at an edge sets `lowside_on` to 1 and sets `pgood` and `pwm_en` to 0 from that edge on. Code 4 is stored if no earlier fault exists.
- R8: `lowside_on` stays 1 while `below_flag` is low. The edge after `below_flag` is sampled high with `ov_flag` low clears `lowside_on`. `pgood` stays 0 until re-armed.
- R9: A new overvoltage after a completed pull-down sets `lowside_on` again, and the stored code is kept.
- R10: `fault_code` keeps the first fault only (1 way-overcurrent, 2 overcurrent, 3 imbalance, 4 overvoltage). When faults arrive together, the order is 1 before 3 before 2 before 4.
- R11: A `rearm` pulse clears the latched shutdown and sets the code to 0, but it does not end a pull-down in progress. `pgood` returns to 1 only once the pull-down has also ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| us_tick | input | 1 | One-clock pulse per microsecond |
| oc_flag | input | 1 | Average current above the overcurrent limit |
| woc_flag | input | 1 | Current above 1.5 times the limit |
| imb_flag | input | 1 | Phase current-sense spread above 9 mV |
| ov_flag | input | 1 | Output above target plus 200 mV |
| below_flag | input | 1 | Output below target |
| rearm | input | 1 | Clears latched faults and the code |
| pgood | output | 1 | Power-good |
| pwm_en | output | 1 | PWM allowed to switch |
| lowside_on | output | 1 | Force low-side switches on |
| fault_code | output | 3 | First fault seen, 0 if none |

## Verification
A table applies single-clock patterns and checks the result: no flag, way-overcurrent alone, overvoltage alone, both together, and brief overcurrent or imbalance pulses. Comparing these rows separates the instant faults from the qualified ones, the latch-off response from the pull-down response, and checks the priority of the code. Directed runs stop the timers one tick short of the limit and exactly at it, interrupt the count with a one-clock gap, repeat the overvoltage after a completed pull-down, and re-arm during a pull-down. These runs show the boundary cycle, the counter restart, the pull-down repeating and re-arm leaving the pull-down alone.

// File: rtl/fps_pkg.sv
package fps_pkg;

    typedef enum logic [2:0] {
        FC_NONE = 3'd0,
        FC_WOC  = 3'd1,
        FC_OC   = 3'd2,
        FC_IMB  = 3'd3,
        FC_OV   = 3'd4
    } fault_code_e;

    typedef enum logic [0:0] {
        PD_IDLE = 1'b0,
        PD_PULL = 1'b1
    } pull_state_e;

    typedef struct packed {
        logic        shut;
        fault_code_e code;
    } latch_state_t;

endpackage

// File: rtl/fps_persist.sv
module fps_persist #(
    parameter int LIMIT = 120
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flag,
    input  logic tick,
    output logic trip
);
    localparam int W = $clog2(LIMIT + 1);
    localparam logic [W-1:0] TOP = W'(LIMIT);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!flag) begin
            cnt_d = '0;
        end else if (tick && (cnt_q != TOP)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign trip = flag && (cnt_q == TOP);
endmodule

// File: rtl/fps_ov_pull.sv
module fps_ov_pull
    import fps_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ov_flag,
    input  logic below_flag,
    output logic pull
);
    pull_state_e st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            PD_IDLE: if (ov_flag) st_d = PD_PULL;
            PD_PULL: if (below_flag && !ov_flag) st_d = PD_IDLE;
            default: st_d = PD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= PD_IDLE;
        else        st_q <= st_d;
    end

    assign pull = (st_q == PD_PULL);
endmodule

// File: rtl/fps_fault_latch.sv
module fps_fault_latch
    import fps_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        woc_flag,
    input  logic        oc_trip,
    input  logic        imb_trip,
    input  logic        ov_flag,
    input  logic        rearm,
    output logic        shut,
    output fault_code_e code
);
    latch_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rearm) begin
            st_d.shut = 1'b0;
            st_d.code = FC_NONE;
        end else begin
            if (woc_flag || oc_trip || imb_trip || ov_flag) st_d.shut = 1'b1;
            if (st_q.code == FC_NONE) begin
                if (woc_flag)      st_d.code = FC_WOC;
                else if (imb_trip) st_d.code = FC_IMB;
                else if (oc_trip)  st_d.code = FC_OC;
                else if (ov_flag)  st_d.code = FC_OV;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{shut: 1'b0, code: FC_NONE};
        else        st_q <= st_d;
    end

    assign shut = st_q.shut;
    assign code = st_q.code;
endmodule

// File: rtl/reg_fault_supervisor.sv
module reg_fault_supervisor
    import fps_pkg::*;
#(
    parameter int OC_US  = 120,
    parameter int IMB_US = 1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       us_tick,
    input  logic       oc_flag,
    input  logic       woc_flag,
    input  logic       imb_flag,
    input  logic       ov_flag,
    input  logic       below_flag,
    input  logic       rearm,
    output logic       pgood,
    output logic       pwm_en,
    output logic       lowside_on,
    output logic [2:0] fault_code
);
    logic        oc_trip, imb_trip, shut, pull;
    fault_code_e code;

    fps_persist #(.LIMIT(OC_US)) u_oc_timer (
        .clk(clk), .rst_n(rst_n), .flag(oc_flag), .tick(us_tick), .trip(oc_trip)
    );

    fps_persist #(.LIMIT(IMB_US)) u_imb_timer (
        .clk(clk), .rst_n(rst_n), .flag(imb_flag), .tick(us_tick), .trip(imb_trip)
    );

    fps_ov_pull u_pull (
        .clk(clk), .rst_n(rst_n), .ov_flag(ov_flag), .below_flag(below_flag), .pull(pull)
    );

    fps_fault_latch u_latch (
        .clk(clk), .rst_n(rst_n), .woc_flag(woc_flag), .oc_trip(oc_trip),
        .imb_trip(imb_trip), .ov_flag(ov_flag), .rearm(rearm),
        .shut(shut), .code(code)
    );

    assign pgood      = !shut && !pull;
    assign pwm_en     = !shut && !pull;
    assign lowside_on = pull;
    assign fault_code = code;
endmodule

// File: rtl/fps_checker.sv
module fps_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       woc_flag,
    input logic       ov_flag,
    input logic       below_flag,
    input logic       rearm,
    input logic       pgood,
    input logic       pwm_en,
    input logic       lowside_on,
    input logic [2:0] fault_code
);
    a_r4_woc_shuts: assert property (@(posedge clk) disable iff (!rst_n)
        (woc_flag && !rearm) |=> (!pgood && !pwm_en));

    a_r7_ov_pulls: assert property (@(posedge clk) disable iff (!rst_n)
        ov_flag |=> (lowside_on && !pwm_en && !pgood));

    a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
        (lowside_on && below_flag && !ov_flag) |=> !lowside_on);

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (lowside_on && !below_flag) |=> lowside_on);

    a_r8_no_switching: assert property (@(posedge clk) disable iff (!rst_n)
        lowside_on |-> !pwm_en);

    a_r10_first_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_code != 3'd0 && !rearm) |=> $stable(fault_code));

    a_r10_code_range: assert property (@(posedge clk) disable iff (!rst_n)
        fault_code <= 3'd4);

    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwm_en && !lowside_on && !rearm) |=> !pwm_en);
endmodule

bind reg_fault_supervisor fps_checker u_fps_checker (
    .clk(clk), .rst_n(rst_n), .woc_flag(woc_flag), .ov_flag(ov_flag),
    .below_flag(below_flag), .rearm(rearm), .pgood(pgood), .pwm_en(pwm_en),
    .lowside_on(lowside_on), .fault_code(fault_code)
);

// File: tb/reg_fault_supervisor_test.sv
module reg_fault_supervisor_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic us_tick = 0, oc_flag = 0, woc_flag = 0, imb_flag = 0;
    logic ov_flag = 0, below_flag = 0, rearm = 0;
    logic pgood, pwm_en, lowside_on;
    logic [2:0] fault_code;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    reg_fault_supervisor #(.OC_US(120), .IMB_US(1000)) uut (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .oc_flag(oc_flag),
        .woc_flag(woc_flag), .imb_flag(imb_flag), .ov_flag(ov_flag),
        .below_flag(below_flag), .rearm(rearm), .pgood(pgood), .pwm_en(pwm_en),
        .lowside_on(lowside_on), .fault_code(fault_code)
    );

    // row: woc ov oc imb tick | pgood lowside | code[2:0]
    localparam logic [9:0] VEC [6] = '{
        10'b00000_1_0_000,   // R1 idle
        10'b10000_0_0_001,   // R4 way-overcurrent alone
        10'b01000_0_1_100,   // R7 overvoltage alone
        10'b11000_0_1_001,   // R10 priority woc over ov
        10'b00101_1_0_000,   // R2 one overcurrent tick is not a fault
        10'b00011_1_0_000    // R5 one imbalance tick is not a fault
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick_us();
        us_tick = 1'b1;
        @(negedge clk);
        us_tick = 1'b0;
        @(negedge clk);
    endtask

    task automatic clear_all();
        below_flag = 1'b1;
        rearm = 1'b1;
        @(negedge clk);
        below_flag = 1'b0;
        rearm = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 pgood", pgood, 1);
        chk("R1 pwm_en", pwm_en, 1);
        chk("R1 lowside", lowside_on, 0);
        chk("R1 code", fault_code, 0);

        for (int i = 0; i < 6; i++) begin
            {woc_flag, ov_flag, oc_flag, imb_flag, us_tick} = VEC[i][9:5];
            @(negedge clk);
            {woc_flag, ov_flag, oc_flag, imb_flag, us_tick} = '0;
            chk("R4 R7 R10 table pgood", pgood, VEC[i][4]);
            chk("R4 R7 R10 table pwm_en", pwm_en, VEC[i][4]);
            chk("R7 R10 table lowside", lowside_on, VEC[i][3]);
            chk("R10 table code", fault_code, VEC[i][2:0]);
            clear_all();
        end

        // R2 boundary
        oc_flag = 1'b1;
        repeat (119) tick_us();
        chk("R2 no fault at 119", pgood, 1);
        tick_us();
        chk("R2 fault at 120", pgood, 0);
        chk("R2 code", fault_code, 2);
        oc_flag = 1'b0;
        repeat (3) @(negedge clk);
        chk("R6 oc held pwm_en", pwm_en, 0);
        chk("R6 oc lowside off", lowside_on, 0);
        clear_all();
        chk("R11 rearm pgood", pgood, 1);
        chk("R11 rearm code", fault_code, 0);

        // R3 restart
        oc_flag = 1'b1;
        repeat (100) tick_us();
        oc_flag = 1'b0;
        @(negedge clk);
        oc_flag = 1'b1;
        repeat (100) tick_us();
        oc_flag = 1'b0;
        @(negedge clk);
        chk("R3 oc restart", pgood, 1);
        imb_flag = 1'b1;
        repeat (600) tick_us();
        imb_flag = 1'b0;
        @(negedge clk);
        imb_flag = 1'b1;
        repeat (600) tick_us();
        imb_flag = 1'b0;
        @(negedge clk);
        chk("R3 imb restart", pgood, 1);

        // R5 boundary
        imb_flag = 1'b1;
        repeat (999) tick_us();
        chk("R5 no fault at 999", pgood, 1);
        tick_us();
        chk("R5 fault at 1000", pgood, 0);
        chk("R5 code", fault_code, 3);
        imb_flag = 1'b0;
        repeat (2) @(negedge clk);
        chk("R6 imb held pgood", pgood, 0);
        clear_all();

        // R8 / R9 pull-down cycle
        ov_flag = 1'b1;
        @(negedge clk);
        ov_flag = 1'b0;
        chk("R7 lowside", lowside_on, 1);
        repeat (5) @(negedge clk);
        chk("R8 lowside held", lowside_on, 1);
        below_flag = 1'b1;
        @(negedge clk);
        below_flag = 1'b0;
        chk("R8 lowside released", lowside_on, 0);
        chk("R8 pgood still low", pgood, 0);
        woc_flag = 1'b1;
        @(negedge clk);
        woc_flag = 1'b0;
        chk("R10 first code kept", fault_code, 4);
        ov_flag = 1'b1;
        @(negedge clk);
        ov_flag = 1'b0;
        chk("R9 pull again", lowside_on, 1);
        chk("R9 code kept", fault_code, 4);

        // R11 rearm during pull-down
        rearm = 1'b1;
        @(negedge clk);
        rearm = 1'b0;
        chk("R11 pull continues", lowside_on, 1);
        chk("R11 pgood low while pulling", pgood, 0);
        chk("R11 code cleared", fault_code, 0);
        below_flag = 1'b1;
        @(negedge clk);
        below_flag = 1'b0;
        chk("R11 pgood back", pgood, 1);
        chk("R11 pwm back", pwm_en, 1);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule